// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host-side request port and the write side of an asynchronous parallel NOR flash bus. A host hands it one high-level flash operation at a time: return to array read, identifier mode entry, query mode entry, single-word program, buffered program, sector erase or whole-chip erase. The block expands the request into the fixed series of bus writes the flash expects, including the two-write unlock preamble where the command needs one, and drives each write as a timed window on an address/data/strobe master port.

For buffered program the data words come in on a separate ready/valid stream. The block holds the bus idle until each word is present, so a slow producer stretches the operation but never corrupts it. The block reports the end of an operation with a one-clock done pulse after the final write window closes. It refuses malformed requests with a one-clock error pulse and issues no bus traffic for them. Completion polling of the flash and bank selection belong to the surrounding logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, bus_cyc is 0, bus_we_n is 1, and done and err are 0.
- R2: Identifier entry, single-word program, buffered program, sector erase and chip erase all begin with two writes: data 0xAA at word address 0x555, then data 0x55 at word address 0x2AA.
- R3: Single-word program (req_op 3) issues four writes: the unlock pair, 0xA0 at 0x555, then req_data at req_addr.
- R4: Identifier entry (req_op 1) issues three writes: the unlock pair, then 0x90 at 0x555. Return to read (req_op 0) issues one write, 0xF0 at address 0.
- R5: Query entry (req_op 2) issues exactly one write, 0x98 at word address 0x55, with no unlock pair.
- R6: Sector erase (req_op 5) issues six writes: the unlock pair, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at req_addr. Chip erase (req_op 6) issues the same first five writes and ends with 0x10 at 0x555.
- R7: Buffered program (req_op 4) with count N issues the unlock pair, then 0x25 at req_addr, then N-1 at req_addr, then the N stream words at req_addr+0 through req_addr+N-1 in arrival order, then 0x29 at req_addr+N-1.
- R8: A request is accepted on a clock where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the clock after the single-cycle done pulse, which follows the close of the last write window. A request held during that time is taken only afterwards.
- R9: wd_ready is 1 only while the block is waiting for a buffered data word. No write window opens until that word has been taken.
- R10: A buffered program request with count 0 or count above BUF_MAX, or a request with req_op 7, is consumed. It raises err for exactly one clock, starts no bus cycle and gives no done pulse.
- R11: Each write keeps bus_cyc at 1 for SLOT clocks with address and data unchanged. bus_we_n is 0 only on the clocks strictly inside that window, which is SLOT-2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 3 | Operation code (0 read, 1 ident, 2 query, 3 program, 4 buffered, 5 sector erase, 6 chip erase) |
| req_addr | input | AW | Target, sector or buffer start word address |
| req_data | input | DW | Data word for single-word program |
| req_count | input | CW | Word count for buffered program |
| wd_valid | input | 1 | Buffered data word offered |
| wd_ready | output | 1 | Block taking a buffered data word |
| wd_data | input | DW | Buffered data word |
| bus_cyc | output | 1 | Write window active |
| bus_addr | output | AW | Bus word address |
| bus_data | output | DW | Bus write data |
| bus_we_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock pulse when an operation completes |
| err | output | 1 | One-clock pulse on a refused request |

## Verification
Two things can happen on the same clock. The done pulse of one operation can meet a request the host is already offering, and the strobe window of a buffered load can meet a data word that has just arrived. The bench holds req_valid high across the end of a sector erase, with the next request's fields changed after acceptance. It then checks that req_ready stays 0 during the done clock and that the second request's writes appear only after the first script is complete. Buffered words are offered with random gaps and with one long stall. The judge is the exact write list and the absence of any write window while the block waits for a word.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int BUF_MAX = 32,
  parameter int SLOT    = 4,
  localparam int CW     = $clog2(BUF_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] req_count,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic          bus_cyc,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          bus_we_n,
  output logic          done,
  output logic          err
);
  localparam int SW = CW + 3;
  localparam int TW = (SLOT > 2) ? $clog2(SLOT) : 2;

  localparam logic [2:0] OP_RESET = 3'd0;
  localparam logic [2:0] OP_IDENT = 3'd1;
  localparam logic [2:0] OP_QUERY = 3'd2;
  localparam logic [2:0] OP_PROG  = 3'd3;
  localparam logic [2:0] OP_BUF   = 3'd4;
  localparam logic [2:0] OP_SECT  = 3'd5;
  localparam logic [2:0] OP_CHIP  = 3'd6;

  localparam logic [AW-1:0] A_555 = AW'(12'h555);
  localparam logic [AW-1:0] A_2AA = AW'(12'h2AA);
  localparam logic [AW-1:0] A_055 = AW'(12'h055);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SLOT, ST_DONE} st_t;

  st_t           state;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] step;
  logic [TW-1:0] tick;
  logic [AW-1:0] bus_addr_q;
  logic [DW-1:0] bus_data_q;
  logic          err_q;

  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          s_word;
  logic [SW-1:0] last_step;
  logic [SW-1:0] wofs;
  logic          bad_req;

  assign wofs    = step - SW'(4);
  assign bad_req = (req_op == 3'd7) ||
                   ((req_op == OP_BUF) && ((req_count == '0) || (req_count > CW'(BUF_MAX))));

  always_comb begin
    case (op_q)
      OP_IDENT: last_step = SW'(2);
      OP_PROG:  last_step = SW'(3);
      OP_BUF:   last_step = SW'(cnt_q) + SW'(4);
      OP_SECT,
      OP_CHIP:  last_step = SW'(5);
      default:  last_step = '0;
    endcase
  end

  always_comb begin
    s_addr = '0;
    s_data = '0;
    s_word = 1'b0;
    case (op_q)
      OP_RESET: s_data = DW'(8'hF0);
      OP_QUERY: begin s_addr = A_055; s_data = DW'(8'h98); end
      default: begin
        if (step == SW'(0)) begin
          s_addr = A_555; s_data = DW'(8'hAA);
        end else if (step == SW'(1)) begin
          s_addr = A_2AA; s_data = DW'(8'h55);
        end else begin
          case (op_q)
            OP_IDENT: begin s_addr = A_555; s_data = DW'(8'h90); end
            OP_PROG: begin
              if (step == SW'(2)) begin s_addr = A_555;  s_data = DW'(8'hA0); end
              else                begin s_addr = addr_q; s_data = data_q;     end
            end
            OP_BUF: begin
              if (step == SW'(2)) begin
                s_addr = addr_q; s_data = DW'(8'h25);
              end else if (step == SW'(3)) begin
                s_addr = addr_q; s_data = DW'(cnt_q - CW'(1));
              end else if (step < SW'(cnt_q) + SW'(4)) begin
                s_addr = addr_q + AW'(wofs); s_word = 1'b1;
              end else begin
                s_addr = addr_q + AW'(cnt_q) - AW'(1); s_data = DW'(8'h29);
              end
            end
            default: begin
              case (step)
                SW'(2):  begin s_addr = A_555; s_data = DW'(8'h80); end
                SW'(3):  begin s_addr = A_555; s_data = DW'(8'hAA); end
                SW'(4):  begin s_addr = A_2AA; s_data = DW'(8'h55); end
                default: begin
                  if (op_q == OP_SECT) begin s_addr = addr_q; s_data = DW'(8'h30); end
                  else                 begin s_addr = A_555;  s_data = DW'(8'h10); end
                end
              endcase
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      cnt_q      <= '0;
      step       <= '0;
      tick       <= '0;
      bus_addr_q <= '0;
      bus_data_q <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (bad_req) begin
              err_q <= 1'b1;
            end else begin
              op_q   <= req_op;
              addr_q <= req_addr;
              data_q <= req_data;
              cnt_q  <= req_count;
              step   <= '0;
              state  <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (!s_word || wd_valid) begin
            bus_addr_q <= s_addr;
            bus_data_q <= s_word ? wd_data : s_data;
            tick       <= '0;
            state      <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (tick == TW'(SLOT - 1)) begin
            if (step == last_step) begin
              state <= ST_DONE;
            end else begin
              step  <= step + SW'(1);
              state <= ST_LOAD;
            end
          end else begin
            tick <= tick + TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign wd_ready  = (state == ST_LOAD) && s_word;
  assign bus_cyc   = (state == ST_SLOT);
  assign bus_we_n  = !(bus_cyc && (tick != '0) && (tick != TW'(SLOT - 1)));
  assign bus_addr  = bus_addr_q;
  assign bus_data  = bus_data_q;
  assign done      = (state == ST_DONE);
  assign err       = err_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          wd_ready,
  input logic          bus_cyc,
  input logic          bus_we_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          done,
  input logic          err
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) bus_cyc |-> !req_ready); // R8
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(bus_cyc)); // R8
  AST_WORD_WAIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) wd_ready |-> !bus_cyc); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!bus_cyc && !done)); // R10
  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) !bus_we_n |-> bus_cyc); // R11
  AST_STROBE_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_we_n) |-> $past(bus_cyc)); // R11
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && $past(bus_cyc)) |-> ($stable(bus_addr) && $stable(bus_data))); // R11
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wd_ready(wd_ready),
  .bus_cyc(bus_cyc), .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data),
  .done(done), .err(err)
);

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/100ps
module test_nor_cmd_seq;
  localparam int AW = 24, DW = 16, BUF_MAX = 32, SLOT = 4;
  localparam int CW = $clog2(BUF_MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wd_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0, wd_data = '0;
  logic [CW-1:0] req_count = '0;
  logic req_ready, wd_ready, bus_cyc, bus_we_n, done, err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;

  always #2 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .BUF_MAX(BUF_MAX), .SLOT(SLOT)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_count(req_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_data(bus_data), .bus_we_n(bus_we_n),
    .done(done), .err(err));

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] rec_a [0:63];
  logic [DW-1:0] rec_d [0:63];
  int rec_n = 0;
  logic [AW-1:0] exp_a [0:63];
  logic [DW-1:0] exp_d [0:63];
  int exp_n = 0;
  logic [DW-1:0] wq [0:63];
  int wq_n = 0, wq_i = 0, stall_left = 0;
  bit pend = 0, prev_we = 1, gappy = 0;
  int low_len = 0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_we_n && prev_we) begin
        if (rec_n < 64) begin rec_a[rec_n] = bus_addr; rec_d[rec_n] = bus_data; end
        rec_n++;
      end
      if (!bus_we_n) low_len++;
      else if (!prev_we) begin
        chk(low_len == SLOT - 2, "R11", "strobe low clocks", low_len, SLOT - 2);
        low_len = 0;
      end
      prev_we = bus_we_n;
    end
  end

  always @(negedge clk) begin
    if (pend) begin wq_i++; wd_valid = 1'b0; end
    if (!wd_valid) begin
      if (stall_left > 0) stall_left--;
      else if (wq_i < wq_n && (!gappy || ($urandom % 3) != 0)) begin
        wd_valid = 1'b1; wd_data = wq[wq_i];
      end
    end
    pend = wd_valid && wd_ready;
  end

  task automatic tick();
    @(negedge clk); #0.2;
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic build_exp(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    exp_n = 0;
    if (op == 3'd0) begin put('0, 16'hF0); return; end
    if (op == 3'd2) begin put(24'h55, 16'h98); return; end
    put(24'h555, 16'hAA); put(24'h2AA, 16'h55);
    case (op)
      3'd1: put(24'h555, 16'h90);
      3'd3: begin put(24'h555, 16'hA0); put(a, d); end
      3'd4: begin
        put(a, 16'h25); put(a, DW'(n - 1));
        for (int k = 0; k < n; k++) put(a + AW'(k), wq[k]);
        put(a + AW'(n - 1), 16'h29);
      end
      default: begin
        put(24'h555, 16'h80); put(24'h555, 16'hAA); put(24'h2AA, 16'h55);
        if (op == 3'd5) put(a, 16'h30); else put(24'h555, 16'h10);
      end
    endcase
  endtask

  task automatic drive(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    req_op = op; req_addr = a; req_data = d; req_count = CW'(n);
  endtask

  task automatic wait_done_cmp(input logic [2:0] op);
    while (!done) tick();
    chk(req_ready == 1'b0, "R8", "ready during done", req_ready, 0);
    chk(rec_n == exp_n, tag_of(op), "write count", rec_n, exp_n);
    for (int k = 0; k < exp_n && k < rec_n; k++) begin
      string t = (k < 2 && op != 3'd0 && op != 3'd2) ? "R2" : tag_of(op);
      chk(rec_a[k] == exp_a[k], t, $sformatf("op%0d addr #%0d", op, k), rec_a[k], exp_a[k]);
      chk(rec_d[k] == exp_d[k], t, $sformatf("op%0d data #%0d", op, k), rec_d[k], exp_d[k]);
    end
    tick();
    chk(done == 1'b0 && req_ready == 1'b1, "R8", "done one clock then ready", {done, req_ready}, 2'b01);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    rec_n = 0;
    build_exp(op, a, d, n);
    drive(op, a, d, n);
    req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8", "ready low after accept", req_ready, 0);
    wait_done_cmp(op);
  endtask

  task automatic load_words(input int n);
    for (int k = 0; k < n; k++) wq[k] = DW'($urandom);
    wq_n = n; wq_i = 0;
  endtask

  task automatic run_bad(input logic [2:0] op, input int n);
    rec_n = 0;
    drive(op, 24'h1234, 16'h0, n);
    req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    chk(err == 1'b1, "R10", "err pulse", err, 1);
    chk(bus_cyc == 1'b0, "R10", "no window on refuse", bus_cyc, 0);
    tick();
    chk(err == 1'b0 && req_ready == 1'b1, "R10", "err one clock", {err, req_ready}, 2'b01);
    repeat (SLOT + 3) tick();
    chk(rec_n == 0 && done == 1'b0, "R10", "no writes after refuse", rec_n, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(bus_cyc == 1'b0 && bus_we_n == 1'b1, "R1", "reset bus idle", {bus_cyc, bus_we_n}, 2'b01);
    chk(done == 1'b0 && err == 1'b0, "R1", "reset pulses low", {done, err}, 2'b00);

    for (int op = 0; op < 7; op++) begin
      if (op == 4) load_words(5);
      run_op(3'(op), 24'h00ABC0, 16'hBEEF, 5);
    end

    load_words(1);  run_op(3'd4, 24'h000100, 16'h0, 1);
    load_words(BUF_MAX); run_op(3'd4, 24'hFFFFF0, 16'h0, BUF_MAX);

    load_words(3);
    stall_left = 30;
    rec_n = 0;
    build_exp(3'd4, 24'h2000, 16'h0, 3);
    drive(3'd4, 24'h2000, 16'h0, 3);
    req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    repeat (20) tick();
    chk(rec_n == 4, "R9", "writes before first word", rec_n, 4);
    chk(wd_ready == 1'b1 && bus_cyc == 1'b0, "R9", "waiting for word", {wd_ready, bus_cyc}, 2'b10);
    wait_done_cmp(3'd4);

    rec_n = 0;
    build_exp(3'd5, 24'h4000, 16'h0, 1);
    drive(3'd5, 24'h4000, 16'h0, 1);
    req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    drive(3'd3, 24'h5555, 16'h1357, 1);
    wait_done_cmp(3'd5);
    rec_n = 0;
    build_exp(3'd3, 24'h5555, 16'h1357, 1);
    tick();
    req_valid = 1'b0;
    wait_done_cmp(3'd3);

    run_bad(3'd4, 0);
    run_bad(3'd4, BUF_MAX + 1);
    run_bad(3'd7, 3);

    gappy = 1;
    for (int it = 0; it < 40; it++) begin
      logic [2:0] op = 3'($urandom % 7);
      int n = 1 + ($urandom % BUF_MAX);
      if (op == 3'd4) load_words(n);
      run_op(op, AW'($urandom), DW'($urandom), n);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule